// File: doc/BRIEF.md
# Per-CPU Level Interrupt Aggregator

This block gathers a configurable number of level-sensitive interrupt sources, grouped in 32-bit words, and produces one registered interrupt line for each CPU. Every CPU owns a private register bank. Software in that CPU writes enable masks into its bank and reads back the raw pending state of all sources. The line for a CPU rises when any source is pending and enabled in that CPU's bank. Because each bank holds its own masks, one source can go to one CPU and be masked for another.

Register access uses a minimal single-cycle bus: a word address, a write strobe, write data, and read data that is registered and valid in the cycle after the address is presented. Inside a bank, the register words come in reversed order relative to source numbering, so the lowest word address holds the highest-numbered sources. The enable registers are plain read/write words, so one write replaces all 32 mask bits. There is no set-bit or clear-bit register.

Top module: `pcpu_irq_ctrl`

## Requirements
- R1: Addressing is by 32-bit word. CPU c owns the 2*NUM_WORDS words starting at word address c*2*NUM_WORDS. Within that bank, slots 0..NUM_WORDS-1 are enable registers and slots NUM_WORDS..2*NUM_WORDS-1 are status registers.
- R2: Register slot k of either group covers sources 32*(NUM_WORDS-1-k) to 32*(NUM_WORDS-1-k)+31, with bit b mapping to source 32*(NUM_WORDS-1-k)+b. With two words, slot 0 covers sources 32..63 and slot 1 covers sources 0..31.
- R3: A write to an enable slot replaces all 32 bits of that slot, and a later read of the slot returns the written value.
- R4: A write to one CPU's bank leaves the enable registers of every other CPU unchanged.
- R5: A status bit reports its source input regardless of any enable. It follows the input two clock edges after the input changes, through a two-flop synchronizer.
- R6: cpu_irq_o[c] is registered and equals the OR over all words of (status AND CPU c's enable). It changes at the first edge after a status or enable change, which is the third edge after a source input change.
- R7: Reset clears every enable bit, every status bit, every interrupt output and the read data.
- R8: Writes to status slots are ignored: the enables and the status readback stay unchanged.
- R9: Word addresses at or above 2*NUM_WORDS*NUM_CPUS read as zero, and writes to them are ignored.
- R10: bus_rdata_o shows the register selected by bus_addr_i at the previous clock edge. It does not change between edges.
- R11: The configuration must have NUM_WORDS equal to 2 or 4, NUM_CPUS of at least 1, and an address width large enough for all banks. Any other configuration is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_src_i | input | NUM_WORDS*32 | Level interrupt sources; bit n is source n |
| bus_addr_i | input | ADDR_W | Word address of the register access |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| cpu_irq_o | output | NUM_CPUS | Registered interrupt line per CPU |

## Verification
The bench targets the reversed word order by walking a single set source bit across all 64 sources. A design that did not reverse the word order would report bit 5 in the wrong status slot and still raise the interrupt, so the status readback catches it where the interrupt line alone would not. A full read sweep over the whole address space after stray writes to status slots and unmapped words exposes three faults: an address decoder that aliases high addresses onto a bank, one that lets a status write land in an enable register, or one that leaks a write into the other CPU's bank. Cycle-exact samples around a source edge and around an enable clear catch a missing or extra register stage in the synchronizer or the output path.

// File: rtl/pcpu_irq_pkg.sv
package pcpu_irq_pkg;
   localparam int unsigned IRQ_WORD_BITS = 32;
   typedef logic [IRQ_WORD_BITS-1:0] irq_word_t;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/pcpu_irq_sync.sv
module pcpu_irq_sync #(
   parameter int unsigned WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   logic [WIDTH-1:0] meta_q;
   logic [WIDTH-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         sync_q <= '0;
      end else begin
         meta_q <= async_i;
         sync_q <= meta_q;
      end
   end

   assign sync_o = sync_q;
endmodule

// File: rtl/pcpu_irq_decode.sv
module pcpu_irq_decode #(
   parameter int unsigned NUM_WORDS = 2,
   parameter int unsigned NUM_CPUS  = 2,
   parameter int unsigned ADDR_W    = 6,
   localparam int unsigned SLOT_W   = $clog2(2 * NUM_WORDS),
   localparam int unsigned IDX_W    = pcpu_irq_pkg::idx_width(NUM_WORDS),
   localparam int unsigned CPU_W    = pcpu_irq_pkg::idx_width(NUM_CPUS)
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output logic [CPU_W-1:0]  cpu_o,
   output logic              is_status_o,
   output logic [IDX_W-1:0]  idx_o
);
   logic [ADDR_W-1:0] region;

   assign region      = addr_i >> SLOT_W;
   assign hit_o       = (region < ADDR_W'(NUM_CPUS));
   assign cpu_o       = region[CPU_W-1:0];
   assign is_status_o = addr_i[SLOT_W-1];
   assign idx_o       = addr_i[IDX_W-1:0];
endmodule

// File: rtl/pcpu_irq_bank.sv
module pcpu_irq_bank #(
   parameter int unsigned NUM_WORDS = 2,
   localparam int unsigned IDX_W    = pcpu_irq_pkg::idx_width(NUM_WORDS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en_i,
   input  logic [IDX_W-1:0]            wr_idx_i,
   input  pcpu_irq_pkg::irq_word_t     wr_data_i,
   input  logic [NUM_WORDS-1:0][31:0]  status_i,
   output logic [NUM_WORDS-1:0][31:0]  en_o,
   output logic                        irq_o
);
   logic [NUM_WORDS-1:0][31:0] en_q;
   logic [NUM_WORDS-1:0]       word_hit;
   logic                       irq_q;

   for (genvar k = 0; k < NUM_WORDS; k++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            en_q[k] <= '0;
         else if (wr_en_i && (wr_idx_i == IDX_W'(k)))
            en_q[k] <= wr_data_i;
      end

      // slot k of the bank masks source word NUM_WORDS-1-k
      assign word_hit[k] = |(en_q[k] & status_i[NUM_WORDS-1-k]);

      a_r3_write_replaces: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en_i && (wr_idx_i == IDX_W'(k))) |=> (en_q[k] == $past(wr_data_i)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |word_hit;
   end

   assign en_o  = en_q;
   assign irq_o = irq_q;

   a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(|en_q));
endmodule

// File: rtl/pcpu_irq_ctrl.sv
module pcpu_irq_ctrl #(
   parameter int unsigned NUM_WORDS = 2,
   parameter int unsigned NUM_CPUS  = 2,
   parameter int unsigned ADDR_W    = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_WORDS*32-1:0]     irq_src_i,
   input  logic [ADDR_W-1:0]           bus_addr_i,
   input  logic                        bus_we_i,
   input  logic [31:0]                 bus_wdata_i,
   output logic [31:0]                 bus_rdata_o,
   output logic [NUM_CPUS-1:0]         cpu_irq_o
);
   localparam int unsigned SRC_BITS = NUM_WORDS * pcpu_irq_pkg::IRQ_WORD_BITS;
   localparam int unsigned SLOT_W   = $clog2(2 * NUM_WORDS);
   localparam int unsigned IDX_W    = pcpu_irq_pkg::idx_width(NUM_WORDS);
   localparam int unsigned CPU_W    = pcpu_irq_pkg::idx_width(NUM_CPUS);

   // R11: configuration checks at elaboration
   if (!(NUM_WORDS == 2 || NUM_WORDS == 4)) begin : g_bad_words
      $error("pcpu_irq_ctrl: NUM_WORDS must be 2 or 4");
   end
   if (NUM_CPUS < 1) begin : g_bad_cpus
      $error("pcpu_irq_ctrl: NUM_CPUS must be at least 1");
   end
   if (ADDR_W < SLOT_W + CPU_W) begin : g_bad_addr
      $error("pcpu_irq_ctrl: ADDR_W too small for all banks");
   end

   logic [SRC_BITS-1:0]                 status_flat;
   logic [NUM_WORDS-1:0][31:0]          status_w;
   logic [NUM_WORDS-1:0][31:0]          status_by_slot;
   logic [NUM_CPUS-1:0][NUM_WORDS-1:0][31:0] en_all;
   logic                                hit;
   logic [CPU_W-1:0]                    cpu_sel;
   logic                                is_status;
   logic [IDX_W-1:0]                    idx;
   logic [31:0]                         rd_d;
   logic [31:0]                         rd_q;

   pcpu_irq_sync #(.WIDTH(SRC_BITS)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (irq_src_i),
      .sync_o  (status_flat)
   );

   pcpu_irq_decode #(
      .NUM_WORDS (NUM_WORDS),
      .NUM_CPUS  (NUM_CPUS),
      .ADDR_W    (ADDR_W)
   ) u_dec (
      .addr_i      (bus_addr_i),
      .hit_o       (hit),
      .cpu_o       (cpu_sel),
      .is_status_o (is_status),
      .idx_o       (idx)
   );

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      assign status_w[w]                     = status_flat[w*32 +: 32];
      assign status_by_slot[NUM_WORDS-1-w]   = status_flat[w*32 +: 32];
   end

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      logic bank_we;
      assign bank_we = bus_we_i && hit && !is_status && (cpu_sel == CPU_W'(c));

      pcpu_irq_bank #(.NUM_WORDS(NUM_WORDS)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en_i   (bank_we),
         .wr_idx_i  (idx),
         .wr_data_i (bus_wdata_i),
         .status_i  (status_w),
         .en_o      (en_all[c]),
         .irq_o     (cpu_irq_o[c])
      );

      a_r4_other_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we_i && hit && (cpu_sel != CPU_W'(c))) |=> $stable(en_all[c]));
   end

   always_comb begin
      rd_d = '0;
      if (hit) begin
         if (is_status) rd_d = status_by_slot[idx];
         else           rd_d = en_all[cpu_sel][idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else        rd_q <= rd_d;
   end

   assign bus_rdata_o = rd_q;

   a_r8_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we_i && hit && is_status) |=> $stable(en_all));

   a_r9_unmapped_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we_i && !hit) |=> $stable(en_all));

   a_r9_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> (bus_rdata_o == '0));
endmodule

// File: tb/pcpu_irq_ctrl_tb_top.sv
module pcpu_irq_ctrl_tb_top;
   localparam int NW = 2;
   localparam int NC = 2;
   localparam int AW = 6;
   localparam int CLK_PERIOD = 10;
   localparam int MAPPED = 2 * NW * NC;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NW*32-1:0]  src = '0;
   logic [AW-1:0]     addr = '0;
   logic              we = 1'b0;
   logic [31:0]       wdata = '0;
   logic [31:0]       rdata;
   logic [NC-1:0]     irq;

   int n_checks = 0;
   int n_fail   = 0;
   logic [31:0] en_m [NC][NW];

   always #(CLK_PERIOD/2) clk = ~clk;

   pcpu_irq_ctrl #(.NUM_WORDS(NW), .NUM_CPUS(NC), .ADDR_W(AW)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_src_i   (src),
      .bus_addr_i  (addr),
      .bus_we_i    (we),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .cpu_irq_o   (irq)
   );

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input int a);
      int c, s;
      if (a >= MAPPED) return '0;
      c = a / (2*NW);
      s = a % (2*NW);
      if (s < NW) return en_m[c][s];
      return src[32*(NW-1-(s-NW)) +: 32];
   endfunction

   function automatic logic exp_irq(input int c);
      logic r = 1'b0;
      for (int k = 0; k < NW; k++) r |= |(en_m[c][k] & src[32*(NW-1-k) +: 32]);
      return r;
   endfunction

   task automatic bus_write(input int a, input logic [31:0] d);
      @(negedge clk);
      addr = AW'(a); wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic bus_read(input int a, output logic [31:0] d);
      @(negedge clk);
      addr = AW'(a);
      @(negedge clk);
      d = rdata;
   endtask

   task automatic settle_irq(input string req);
      repeat (3) @(negedge clk);
      for (int c = 0; c < NC; c++) check(32'(irq[c]), 32'(exp_irq(c)), req);
   endtask

   task automatic sweep_all(input string req);
      logic [31:0] d;
      for (int a = 0; a < (1 << AW); a++) begin
         bus_read(a, d);
         check(d, exp_read(a), req);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      logic [31:0] d;
      for (int c = 0; c < NC; c++) for (int k = 0; k < NW; k++) en_m[c][k] = '0;

      // R7: reset state
      repeat (3) @(negedge clk);
      check(rdata, 32'h0, "R7 rdata in reset");
      check(32'(irq), 32'h0, "R7 irq in reset");
      rst_n = 1'b1;
      sweep_all("R7 registers after reset");

      // R1 R3 R4: write each enable slot, full readback
      for (int c = 0; c < NC; c++)
         for (int k = 0; k < NW; k++) begin
            logic [31:0] p = 32'hA5C3_0000 ^ (32'(c) << 8) ^ 32'(k) ^ (32'h1357 * 32'(c*NW+k+1));
            bus_write(c*2*NW + k, p);
            en_m[c][k] = p;
         end
      sweep_all("R1 R3 R4 R9 readback");

      // R8 R9: stray writes to status slots and unmapped words
      for (int c = 0; c < NC; c++)
         for (int k = 0; k < NW; k++) bus_write(c*2*NW + NW + k, 32'hFFFF_FFFF);
      for (int a = MAPPED; a < (1 << AW); a += 3) bus_write(a, 32'hFFFF_FFFF);
      sweep_all("R8 R9 stray writes ignored");
      settle_irq("R8 irq unchanged");

      // R2 R5 R6: walk one source across all inputs
      for (int k = 0; k < NW; k++) begin
         bus_write(k, 32'hFFFF_FFFF);          en_m[0][k] = 32'hFFFF_FFFF;
         bus_write(2*NW + k, 32'h0);           en_m[1][k] = 32'h0;
      end
      for (int i = 0; i < NW*32; i++) begin
         @(negedge clk);
         src = '0; src[i] = 1'b1;
         settle_irq("R6 walking source");
         bus_read(2*NW + NW + (NW-1-i/32), d);
         check(d, 32'h1 << (i % 32), "R2 R5 status slot of disabled cpu");
         bus_read(NW + (i/32 == 0 ? NW-1 : NW-1-i/32), d);
         check(d, 32'h1 << (i % 32), "R2 status slot of enabled cpu");
      end

      // R5 R6: exact latency from source edge
      @(negedge clk); src = '0;
      bus_write(2*NW + (NW-1), 32'h8); en_m[1][NW-1] = 32'h8;
      bus_write(0, 32'h0); en_m[0][0] = 32'h0;
      bus_write(1, 32'h0); en_m[0][1] = 32'h0;
      repeat (3) @(negedge clk);
      @(negedge clk); src[3] = 1'b1;
      @(negedge clk); check(32'(irq[1]), 32'h0, "R5 no irq after 1 edge");
      @(negedge clk); check(32'(irq[1]), 32'h0, "R5 no irq after 2 edges");
      @(negedge clk); check(32'(irq[1]), 32'h1, "R6 irq after 3 edges");
      check(32'(irq[0]), 32'h0, "R4 other cpu stays low");

      // R6: enable clear takes one more edge
      @(negedge clk);
      addr = AW'(2*NW + NW - 1); wdata = '0; we = 1'b1;
      @(negedge clk); we = 1'b0; en_m[1][NW-1] = '0;
      check(32'(irq[1]), 32'h1, "R6 irq still high at enable edge");
      @(negedge clk); check(32'(irq[1]), 32'h0, "R6 irq low one edge later");

      // R10: read data moves only at the edge
      bus_read(2*NW + NW + (NW-1), d);
      check(d, 32'h8, "R10 status read");
      @(negedge clk); addr = AW'(MAPPED);
      #1 check(rdata, 32'h8, "R10 rdata holds before edge");
      @(negedge clk); check(rdata, 32'h0, "R10 rdata after edge");

      // R7: reset in mid-run clears enables
      bus_write(0, 32'hDEAD_BEEF);
      @(negedge clk); rst_n = 1'b0; src = '0;
      @(negedge clk); check(32'(irq), 32'h0, "R7 irq cleared by reset");
      rst_n = 1'b1;
      for (int c = 0; c < NC; c++) for (int k = 0; k < NW; k++) en_m[c][k] = '0;
      sweep_all("R7 enables cleared by reset");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule